// File: doc/BRIEF.md
# Physical Memory Protection Permission Checker

This block decides, for one physical memory access, which of read, write and execute the current privilege mode may use, and whether the requested operation is granted. It compares the access against a small table of protection entries. Each entry supplies a configuration byte and a region that has already been decoded into a base and a limit. The entries are searched from the lowest index upward. The first active entry that touches the access decides the outcome. If it covers only one end of the access, the access fails outright.

Two permission regimes are supported. In the plain regime, machine mode is unrestricted on unlocked entries, and every other case is masked by the entry's own read, write and execute bits. In the lockdown regime, permissions come from a fixed 16-way table that depends on the privilege mode and is indexed by the lock, read, write and execute bits. When no entry is active, or none matches, the permission mask is taken from an input that carries the default policy. The result is computed combinationally and registered once, so it appears one clock after the inputs.

Top module: `prot_perm_check`

## Requirements
- R1: Configuration byte layout: bit 0 is read, bit 1 is write, bit 2 is execute, bits 4:3 are the address-match field and bit 7 is the lock bit. An entry whose address-match field is 0 is off, never matches and is skipped in the search. Any other value of that field makes the entry active.
- R2: An address is inside an entry's region when base <= address < limit. The last byte of an access is address + size - 1, taken modulo 2^ADDR_W.
- R3: A size of zero means the size is unknown. With translation enabled, the last byte is the final byte of the 4 KiB page that holds the address. With translation disabled, the last byte is address + WORD_BYTES - 1.
- R4: Active entries are searched from index 0 upward. The first one that contains both the first and the last byte decides the outputs, and hit_idx reports its index.
- R5: If the first active entry to contain either end of the access contains exactly one of them, the outputs are violation = 1, allow_priv = 0 and grant = 0, and hit_idx reports that entry. Later entries have no effect on this result.
- R6: If no entry is active, or no active entry contains either end of the access, the outputs are allow_priv = dflt_priv, violation = 0 and hit_idx = all ones.
- R7: With lockdown clear, machine mode on an unlocked entry gets all three permissions (3'b111). A lower mode, or machine mode on a locked entry, gets only the entry's bits 2:0.
- R8: With lockdown set in machine mode, the index {L,R,W,X} gives the following permissions: 0, 1, 4, 5, 6, 7 and 8 give nothing; 2, 3 and 14 give read+write; 9 and 10 give execute; 11 and 13 give read+execute; 12 and 15 give read.
- R9: With lockdown set in a lower mode, the same index gives the following permissions: 0, 8, 9, 12, 13 and 14 give nothing; 1, 10 and 11 give execute; 2, 4 and 15 give read; 3 and 6 give read+write; 5 gives read+execute; 7 gives all three.
- R10: grant is 1 exactly when there is no violation and every bit set in req_priv is also set in allow_priv. Permission vectors are encoded as bit 0 read, bit 1 write, bit 2 execute.
- R11: All outputs are registered and reflect the inputs present at the previous rising clock edge. While rst is high they are allow_priv = 0, grant = 0, violation = 0 and hit_idx = all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ent_cfg | input | 8*N_ENTRIES | Configuration bytes; entry i occupies bits 8i+7:8i |
| ent_base | input | ADDR_W*N_ENTRIES | Inclusive region bases, entry i in slice i |
| ent_limit | input | ADDR_W*N_ENTRIES | Exclusive region limits, entry i in slice i |
| acc_addr | input | ADDR_W | Address of the first byte of the access |
| acc_size | input | SIZE_W | Access size in bytes; 0 means unknown |
| xlate_en | input | 1 | Address translation is enabled |
| mach_mode | input | 1 | 1 = machine mode, 0 = a lower mode |
| lockdown | input | 1 | Selects the machine-mode lockdown permission table |
| req_priv | input | 3 | Requested permissions {X,W,R} |
| dflt_priv | input | 3 | Permission mask used when no entry matches |
| allow_priv | output | 3 | Permitted operations {X,W,R} |
| hit_idx | output | $clog2(N_ENTRIES)+1 | Index of the deciding entry, or all ones for no match |
| violation | output | 1 | A partial-match violation occurred |
| grant | output | 1 | The requested access is permitted |

## Verification
The bench builds the checker with N_ENTRIES = 4 and ADDR_W = 16, and leaves WORD_BYTES at 4. With only four entries, random regions packed into a 1 KiB window overlap often. This makes priority between entries, straddling accesses and skipped off entries occur frequently under random stimulus. The narrow address space also keeps the page-end case for unknown size within reach. Both 16-way lockdown tables are swept exhaustively in both privilege modes.

// File: rtl/prot_pkg.sv
package prot_pkg;

  // permission vector {X,W,R}
  typedef logic [2:0] perm_t;

  localparam int CFG_R   = 0;
  localparam int CFG_W   = 1;
  localparam int CFG_X   = 2;
  localparam int CFG_AM0 = 3;
  localparam int CFG_AM1 = 4;
  localparam int CFG_L   = 7;

  localparam perm_t P_NONE = 3'b000;
  localparam perm_t P_R    = 3'b001;
  localparam perm_t P_RW   = 3'b011;
  localparam perm_t P_X    = 3'b100;
  localparam perm_t P_RX   = 3'b101;
  localparam perm_t P_RWX  = 3'b111;

  // lockdown table, machine mode; key = {L,R,W,X}
  function automatic perm_t lock_tbl_mach(input logic [3:0] key);
    case (key)
      4'd2, 4'd3, 4'd14: lock_tbl_mach = P_RW;
      4'd9, 4'd10:       lock_tbl_mach = P_X;
      4'd11, 4'd13:      lock_tbl_mach = P_RX;
      4'd12, 4'd15:      lock_tbl_mach = P_R;
      default:           lock_tbl_mach = P_NONE;
    endcase
  endfunction

  // lockdown table, lower modes; key = {L,R,W,X}
  function automatic perm_t lock_tbl_user(input logic [3:0] key);
    case (key)
      4'd1, 4'd10, 4'd11: lock_tbl_user = P_X;
      4'd2, 4'd4, 4'd15:  lock_tbl_user = P_R;
      4'd3, 4'd6:         lock_tbl_user = P_RW;
      4'd5:               lock_tbl_user = P_RX;
      4'd7:               lock_tbl_user = P_RWX;
      default:            lock_tbl_user = P_NONE;
    endcase
  endfunction

endpackage

// File: rtl/prot_span.sv
module prot_span #(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 4,
  parameter int WORD_BYTES = 4,
  parameter int PAGE_BITS  = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic              xlate_en,
  output logic [ADDR_W-1:0] last_addr
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = {{(ADDR_W-PAGE_BITS){1'b0}}, {PAGE_BITS{1'b1}}};
  localparam logic [ADDR_W-1:0] WORD_SPAN = ADDR_W'(WORD_BYTES - 1);

  logic [ADDR_W-1:0] size_ext;
  assign size_ext = {{(ADDR_W-SIZE_W){1'b0}}, size};

  always_comb begin
    if (size != '0)
      last_addr = addr + size_ext - ADDR_W'(1);
    else if (xlate_en)
      last_addr = addr | PAGE_MASK;
    else
      last_addr = addr + WORD_SPAN;
  end

  // R3
  always_comb begin
    if (size == '0 && xlate_en)
      page_end_chk: assert ((last_addr & PAGE_MASK) == PAGE_MASK);
  end
endmodule

// File: rtl/prot_entry.sv
module prot_entry
  import prot_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [7:0]        cfg,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic              mach_mode,
  input  logic              lockdown,
  output logic              active,
  output logic              hit_first,
  output logic              hit_last,
  output perm_t             perm
);
  logic [3:0] key;
  logic       locked;

  assign active    = (cfg[CFG_AM1:CFG_AM0] != 2'b00);
  assign hit_first = active && (first_addr >= base) && (first_addr < limit);
  assign hit_last  = active && (last_addr  >= base) && (last_addr  < limit);
  assign locked    = cfg[CFG_L];
  assign key       = {cfg[CFG_L], cfg[CFG_R], cfg[CFG_W], cfg[CFG_X]};

  always_comb begin
    if (lockdown)
      perm = mach_mode ? lock_tbl_mach(key) : lock_tbl_user(key);
    else if (mach_mode && !locked)
      perm = P_RWX;
    else
      perm = cfg[2:0];
  end

  // R8
  always_comb begin
    if (lockdown && mach_mode)
      mach_no_rwx_chk: assert (perm != P_RWX);
  end
endmodule

// File: rtl/prot_perm_check.sv
module prot_perm_check
  import prot_pkg::*;
#(
  parameter int N_ENTRIES  = 16,
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 4,
  parameter int WORD_BYTES = 4,
  parameter int PAGE_BITS  = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [8*N_ENTRIES-1:0]        ent_cfg,
  input  logic [ADDR_W*N_ENTRIES-1:0]   ent_base,
  input  logic [ADDR_W*N_ENTRIES-1:0]   ent_limit,
  input  logic [ADDR_W-1:0]             acc_addr,
  input  logic [SIZE_W-1:0]             acc_size,
  input  logic                          xlate_en,
  input  logic                          mach_mode,
  input  logic                          lockdown,
  input  logic [2:0]                    req_priv,
  input  logic [2:0]                    dflt_priv,
  output logic [2:0]                    allow_priv,
  output logic [$clog2(N_ENTRIES):0]    hit_idx,
  output logic                          violation,
  output logic                          grant
);
  localparam int IDX_W = $clog2(N_ENTRIES) + 1;
  localparam logic [IDX_W-1:0] NO_HIT = '1;

  logic [ADDR_W-1:0]    last_addr;
  logic [N_ENTRIES-1:0] act, hf, hl;
  perm_t                ent_perm [N_ENTRIES];

  prot_span #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
    .WORD_BYTES(WORD_BYTES), .PAGE_BITS(PAGE_BITS)
  ) u_span (
    .addr(acc_addr), .size(acc_size), .xlate_en(xlate_en), .last_addr(last_addr)
  );

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    prot_entry #(.ADDR_W(ADDR_W)) u_ent (
      .cfg       (ent_cfg[8*g +: 8]),
      .base      (ent_base[ADDR_W*g +: ADDR_W]),
      .limit     (ent_limit[ADDR_W*g +: ADDR_W]),
      .first_addr(acc_addr),
      .last_addr (last_addr),
      .mach_mode (mach_mode),
      .lockdown  (lockdown),
      .active    (act[g]),
      .hit_first (hf[g]),
      .hit_last  (hl[g]),
      .perm      (ent_perm[g])
    );
  end

  logic             sel_found, sel_viol, grant_d;
  logic [IDX_W-1:0] sel_idx;
  perm_t            sel_perm;

  always_comb begin
    sel_found = 1'b0;
    sel_viol  = 1'b0;
    sel_idx   = NO_HIT;
    sel_perm  = dflt_priv;
    if (act != '0) begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        if (!sel_found && (hf[i] || hl[i])) begin
          sel_found = 1'b1;
          sel_idx   = IDX_W'(i);
          if (hf[i] ^ hl[i]) begin
            sel_viol = 1'b1;
            sel_perm = P_NONE;
          end else begin
            sel_perm = ent_perm[i];
          end
        end
      end
    end
  end

  assign grant_d = !sel_viol && ((req_priv & ~sel_perm) == 3'b000);

  logic primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      allow_priv <= P_NONE;
      hit_idx    <= NO_HIT;
      violation  <= 1'b0;
      grant      <= 1'b0;
      primed     <= 1'b0;
    end else begin
      allow_priv <= sel_perm;
      hit_idx    <= sel_idx;
      violation  <= sel_viol;
      grant      <= grant_d;
      primed     <= 1'b1;
    end
  end

  // R10
  grant_subset_chk: assert property (@(posedge clk) disable iff (rst)
    grant |-> (($past(req_priv) & ~allow_priv) == 3'b000));

  // R5
  viol_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    violation |-> (!grant && allow_priv == 3'b000 && hit_idx != NO_HIT));

  // R6
  miss_default_chk: assert property (@(posedge clk) disable iff (rst)
    (primed && hit_idx == NO_HIT) |-> (allow_priv == $past(dflt_priv) && !violation));

  // R6
  no_active_chk: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(ent_cfg) == '0) |-> (hit_idx == NO_HIT));

  // R1
  idx_active_chk: assert property (@(posedge clk) disable iff (rst)
    (primed && hit_idx != NO_HIT) |-> (hit_idx < IDX_W'(N_ENTRIES)));
endmodule

// File: tb/tb_prot_perm_check.sv
module tb_prot_perm_check;
  localparam int N  = 4;
  localparam int AW = 16;
  localparam int SW = 4;
  localparam int WB = 4;
  localparam int IW = $clog2(N) + 1;

  logic clk = 1'b0;
  logic rst;
  logic [8*N-1:0]  ent_cfg;
  logic [AW*N-1:0] ent_base, ent_limit;
  logic [AW-1:0]   acc_addr;
  logic [SW-1:0]   acc_size;
  logic            xlate_en, mach_mode, lockdown;
  logic [2:0]      req_priv, dflt_priv, allow_priv;
  logic [IW-1:0]   hit_idx;
  logic            violation, grant;

  always #2.5 clk = ~clk;

  prot_perm_check #(.N_ENTRIES(N), .ADDR_W(AW), .SIZE_W(SW), .WORD_BYTES(WB)) dut (
    .clk(clk), .rst(rst), .ent_cfg(ent_cfg), .ent_base(ent_base), .ent_limit(ent_limit),
    .acc_addr(acc_addr), .acc_size(acc_size), .xlate_en(xlate_en), .mach_mode(mach_mode),
    .lockdown(lockdown), .req_priv(req_priv), .dflt_priv(dflt_priv),
    .allow_priv(allow_priv), .hit_idx(hit_idx), .violation(violation), .grant(grant)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0]    cfg_a [N];
  logic [AW-1:0] bas_a [N];
  logic [AW-1:0] lim_a [N];

  // expected table bits per permission, indexed by {L,R,W,X}
  localparam logic [15:0] M_R = 16'hF80C, M_W = 16'h400C, M_X = 16'h2E00;
  localparam logic [15:0] U_R = 16'h80FC, U_W = 16'h00C8, U_X = 16'h0CA2;

  logic [2:0]    e_allow;
  logic [IW-1:0] e_idx;
  logic          e_viol, e_grant;

  task automatic load();
    for (int i = 0; i < N; i++) begin
      ent_cfg[8*i +: 8]    = cfg_a[i];
      ent_base[AW*i +: AW] = bas_a[i];
      ent_limit[AW*i +: AW]= lim_a[i];
    end
  endtask

  task automatic model();
    logic [AW-1:0] last;
    logic s, e, done_l;
    logic [3:0] k;
    if (acc_size != 0) last = acc_addr + AW'(acc_size) - 1;
    else if (xlate_en) last = {acc_addr[AW-1:12], 12'hFFF};
    else last = acc_addr + AW'(WB - 1);
    e_allow = dflt_priv; e_idx = '1; e_viol = 0; done_l = 0;
    for (int i = 0; i < N; i++) begin
      if (!done_l && cfg_a[i][4:3] != 0) begin
        s = (acc_addr >= bas_a[i]) && (acc_addr < lim_a[i]);
        e = (last >= bas_a[i]) && (last < lim_a[i]);
        if (s || e) begin
          done_l = 1; e_idx = IW'(i);
          if (s != e) begin e_viol = 1; e_allow = 0; end
          else if (lockdown) begin
            k = {cfg_a[i][7], cfg_a[i][0], cfg_a[i][1], cfg_a[i][2]};
            e_allow = mach_mode ? {M_X[k], M_W[k], M_R[k]} : {U_X[k], U_W[k], U_R[k]};
          end else if (mach_mode && !cfg_a[i][7]) e_allow = 3'b111;
          else e_allow = cfg_a[i][2:0];
        end
      end
    end
    e_grant = !e_viol && ((req_priv & ~e_allow) == 0);
  endtask

  task automatic run(input string tag);
    load();
    model();
    @(negedge clk);
    n_chk++;
    if (allow_priv !== e_allow || hit_idx !== e_idx || violation !== e_viol || grant !== e_grant) begin
      n_fail++;
      $display("FAIL %s: got allow=%b idx=%0d viol=%b grant=%b exp allow=%b idx=%0d viol=%b grant=%b",
               tag, allow_priv, hit_idx, violation, grant, e_allow, e_idx, e_viol, e_grant);
    end
  endtask

  task automatic clear_ents();
    for (int i = 0; i < N; i++) begin cfg_a[i] = 0; bas_a[i] = 0; lim_a[i] = 0; end
  endtask

  task automatic acc(input logic [AW-1:0] a, input logic [SW-1:0] sz, input logic xl,
                     input logic m, input logic ld, input logic [2:0] rq, input logic [2:0] df);
    acc_addr = a; acc_size = sz; xlate_en = xl; mach_mode = m; lockdown = ld;
    req_priv = rq; dflt_priv = df;
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst = 1; clear_ents(); load();
    acc(16'h0100, 4, 0, 1, 0, 3'b001, 3'b111);
    repeat (3) @(negedge clk);
    // R11 reset values
    n_chk++;
    if (allow_priv !== 0 || grant !== 0 || violation !== 0 || hit_idx !== '1) begin
      n_fail++;
      $display("FAIL R11 reset: got allow=%b idx=%0d viol=%b grant=%b exp 000/all ones/0/0",
               allow_priv, hit_idx, violation, grant);
    end
    rst = 0;

    // R6 no active entry: default mask
    clear_ents(); acc(16'h0100, 4, 0, 0, 0, 3'b011, 3'b011); run("R6 no active");
    acc(16'h0100, 4, 0, 0, 0, 3'b100, 3'b011); run("R6 default denies R10");

    // R7 plain regime
    clear_ents(); cfg_a[1] = 8'h08 | 8'h01; bas_a[1] = 16'h0100; lim_a[1] = 16'h0200;
    acc(16'h0110, 4, 0, 1, 0, 3'b111, 3'b000); run("R7 mach unlocked");
    cfg_a[1] = 8'h88 | 8'h01; run("R7 mach locked");
    cfg_a[1] = 8'h08 | 8'h03; acc(16'h0110, 4, 0, 0, 0, 3'b010, 3'b000); run("R7 lower mode");

    // R1 off entry skipped, R4 priority
    cfg_a[0] = 8'h07; bas_a[0] = 16'h0100; lim_a[0] = 16'h0200; run("R1 off entry skipped");
    cfg_a[0] = 8'h10 | 8'h04; run("R4 lowest wins");

    // R5 partial at entry 0 overrides full cover at entry 1
    cfg_a[0] = 8'h08 | 8'h07; bas_a[0] = 16'h0100; lim_a[0] = 16'h0112;
    cfg_a[1] = 8'h08 | 8'h07; bas_a[1] = 16'h0000; lim_a[1] = 16'h1000;
    acc(16'h0110, 4, 0, 0, 0, 3'b001, 3'b111); run("R5 straddle");
    // R2 limit exclusive, base inclusive
    acc(16'h010E, 4, 0, 0, 0, 3'b001, 3'b111); run("R2 last byte at limit-1");
    acc(16'h0112, 1, 0, 0, 0, 3'b001, 3'b111); run("R2 addr at limit");
    acc(16'h00FF, 1, 0, 0, 0, 3'b001, 3'b111); run("R2 below base");

    // R3 unknown size
    clear_ents(); cfg_a[0] = 8'h0F; bas_a[0] = 16'h2000; lim_a[0] = 16'h2F00;
    acc(16'h2010, 0, 1, 0, 0, 3'b001, 3'b000); run("R3 xlate page end");
    acc(16'h2010, 0, 0, 0, 0, 3'b001, 3'b000); run("R3 native word");
    acc(16'h2EFD, 0, 0, 0, 0, 3'b001, 3'b000); run("R3 word straddles");

    // R8/R9 exhaustive lockdown tables
    for (int k = 0; k < 16; k++) begin
      clear_ents();
      cfg_a[2] = {k[3], 2'b00, 2'b01, k[0], k[1], k[2]};
      bas_a[2] = 16'h0400; lim_a[2] = 16'h0800;
      acc(16'h0500, 2, 0, 1, 1, 3'b001, 3'b111); run("R8 mach table");
      acc(16'h0500, 2, 0, 0, 1, 3'b100, 3'b111); run("R9 lower table");
    end

    // random mix covering R1..R10
    for (int t = 0; t < 400; t++) begin
      for (int i = 0; i < N; i++) begin
        cfg_a[i] = 8'($urandom);
        bas_a[i] = AW'($urandom_range(0, 16'h03C0));
        lim_a[i] = bas_a[i] + AW'($urandom_range(1, 16'h0100));
      end
      if (($urandom & 15) == 0) for (int i = 0; i < N; i++) cfg_a[i][4:3] = 0;
      acc(AW'($urandom_range(0, 16'h03FF)), SW'($urandom_range(0, 8)), 1'($urandom),
          1'($urandom), 1'($urandom), 3'($urandom), 3'($urandom));
      run("R4 R5 R10 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule